// File: doc/BRIEF.md
# Transmit Low Power Idle Sequencer

This block controls when an Ethernet MAC transmit path sends the Low Power Idle pattern and when it returns to normal traffic. Software programs a configuration word and a timer word through a small register port. The block counts millisecond ticks while the link-good bit stays set. It allows LPI entry only when software has forced LPI mode and the link has stayed good for the programmed settle time. On exit it holds transmission for the programmed wake time, counted in microsecond ticks.

Four sticky event flags record transmit entry, transmit exit, receive-side LPI start and receive-side LPI end. A read of the status word clears them. An interrupt line is raised while any flag is set, unless software masks it. The ticks come from an external divider. The receive-side indication comes straight from the PHY.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: A write with `reg_sel_i`=1 loads the wake time from data bits 15:0 and the link-settle time from data bits 26:16. A read with `reg_sel_i`=1 returns those two fields in the same places.
- R2: A write with `reg_sel_i`=0 loads four control bits: link-good (bit 16), LPI enable (bit 17), automate (bit 18) and interrupt mask (bit 19). A read with `reg_sel_i`=0 returns them in the same bits. Bits 0..3 of that read are the flags of R7, bit 8 is the live transmit-LPI state and bit 9 is the registered receive-LPI input. All other bits read 0.
- R3: `tx_lpi_o` rises only if enable and automate are both 1, link-good is 1, `tx_pend_i` is 0, and at least the programmed number of `ms_tick_i` pulses have arrived since link-good was last set. It rises on the clock edge after these conditions all hold. With a settle time of 0, it rises on the edge after they hold.
- R4: Clearing link-good restarts the millisecond count from zero. If the block is in LPI or in the wake wait, clearing link-good also returns it to idle on the next edge, without waiting for the wake time.
- R5: While in LPI, either a pending transmit frame or clearing enable or automate ends LPI. `tx_lpi_o` drops at once, and `tx_hold_o` stays 1 until the programmed number of `us_tick_i` pulses has been counted. With a wake time of 0, the hold lasts one cycle.
- R6: `tx_hold_o` is 1 in LPI and during the wake wait, and 0 in idle.
- R7: Flag bit 0 sets when the block enters transmit LPI. Flag bit 1 sets when it leaves transmit LPI by any path. Flag bit 2 sets on a rising edge of `rx_lpi_i`. Flag bit 3 sets on a falling edge of `rx_lpi_i`.
- R8: A read with `reg_sel_i`=0 clears all flags on that edge. If an event arrives in the same cycle as the read, its flag stays set.
- R9: `irq_o` is 1 when any flag is set and the mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| us_tick_i | input | 1 | One-cycle pulse each microsecond |
| ms_tick_i | input | 1 | One-cycle pulse each millisecond |
| rx_lpi_i | input | 1 | Receive-side LPI indication from the PHY |
| tx_pend_i | input | 1 | A transmit frame is waiting |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (status read clears flags) |
| reg_sel_i | input | 1 | 0 = control/status word, 1 = timer word |
| reg_wdata_i | input | REG_W | Write data |
| reg_rdata_o | output | REG_W | Read data (combinational) |
| tx_lpi_o | output | 1 | Send LPI pattern on the transmit path |
| tx_hold_o | output | 1 | Hold transmit frames |
| irq_o | output | 1 | Event interrupt |

## Verification
The assertions assume that each tick input is a single-cycle pulse. They also assume that read and write strobes are never both high in one cycle, and that the register port is not used during reset. The bench drives every input on the falling clock edge. It raises each tick for exactly one cycle, issues each register access as a one-cycle strobe, and never overlaps a read with a write. It sweeps settle and wake times from 0 to 3. Before each step it clears link-good, so that every sweep point starts from a known millisecond count.

// File: rtl/lpi_pkg.sv
package lpi_pkg;
  typedef enum logic [1:0] {ST_OFF, ST_LPI, ST_WAKE} lpi_state_e;

  localparam int NFLAG      = 4;
  localparam int F_TX_ENTER = 0;
  localparam int F_TX_LEAVE = 1;
  localparam int F_RX_RISE  = 2;
  localparam int F_RX_FALL  = 3;

  localparam int B_TX_LIVE = 8;
  localparam int B_RX_LIVE = 9;
  localparam int B_LINK    = 16;
  localparam int B_EN      = 17;
  localparam int B_AUTO    = 18;
  localparam int B_MASK    = 19;
endpackage

// File: rtl/lpi_regs.sv
module lpi_regs
  import lpi_pkg::*;
#(
  parameter int TW_W  = 16,
  parameter int LS_W  = 11,
  parameter int REG_W = TW_W + LS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              sel_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic [NFLAG-1:0]  flags_i,
  input  logic              tx_live_i,
  input  logic              rx_live_i,
  output logic              link_o,
  output logic              en_o,
  output logic              auto_o,
  output logic              mask_o,
  output logic [TW_W-1:0]   tw_o,
  output logic [LS_W-1:0]   ls_o,
  output logic              rd_clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_o <= 1'b0;
      en_o   <= 1'b0;
      auto_o <= 1'b0;
      mask_o <= 1'b0;
      tw_o   <= '0;
      ls_o   <= '0;
    end else if (wr_i) begin
      if (sel_i) begin
        tw_o <= wdata_i[TW_W-1:0];
        ls_o <= wdata_i[REG_W-1:TW_W];
      end else begin
        link_o <= wdata_i[B_LINK];
        en_o   <= wdata_i[B_EN];
        auto_o <= wdata_i[B_AUTO];
        mask_o <= wdata_i[B_MASK];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      rdata_o = {ls_o, tw_o};
    end else begin
      rdata_o[NFLAG-1:0] = flags_i;
      rdata_o[B_TX_LIVE] = tx_live_i;
      rdata_o[B_RX_LIVE] = rx_live_i;
      rdata_o[B_LINK]    = link_o;
      rdata_o[B_EN]      = en_o;
      rdata_o[B_AUTO]    = auto_o;
      rdata_o[B_MASK]    = mask_o;
    end
  end

  assign rd_clr_o = rd_i & ~sel_i;

  assert_timer_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i) |=> (tw_o == $past(wdata_i[TW_W-1:0])))
    else $error("timer write lost");
endmodule

// File: rtl/lpi_timers.sv
module lpi_timers #(
  parameter int TW_W = 16,
  parameter int LS_W = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            link_i,
  input  logic            ms_tick_i,
  input  logic            us_tick_i,
  input  logic            wake_i,
  input  logic [LS_W-1:0] ls_i,
  input  logic [TW_W-1:0] tw_i,
  output logic            stable_o,
  output logic            tw_done_o
);
  localparam logic [LS_W-1:0] LS_MAX = '1;
  localparam logic [TW_W-1:0] TW_MAX = '1;

  logic [LS_W-1:0] ls_cnt;
  logic [TW_W-1:0] tw_cnt;

  // saturating: a count at max still satisfies any programmed limit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ls_cnt <= '0;
    else if (!link_i)                     ls_cnt <= '0;
    else if (ms_tick_i && ls_cnt != LS_MAX) ls_cnt <= ls_cnt + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          tw_cnt <= '0;
    else if (!wake_i)                     tw_cnt <= '0;
    else if (us_tick_i && tw_cnt != TW_MAX) tw_cnt <= tw_cnt + 1'b1;
  end

  assign stable_o  = link_i && (ls_cnt >= ls_i);
  assign tw_done_o = wake_i && (tw_cnt >= tw_i);

  assert_ls_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(stable_o) && $stable(ls_i) && ls_i != '0) |-> $past(ms_tick_i))
    else $error("link settled without a tick");
  assert_ls_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_i) |=> (ls_cnt == '0))
    else $error("settle count not restarted");
endmodule

// File: rtl/lpi_fsm.sv
module lpi_fsm
  import lpi_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic link_i,
  input  logic en_i,
  input  logic auto_i,
  input  logic stable_i,
  input  logic tx_pend_i,
  input  logic tw_done_i,
  output logic tx_lpi_o,
  output logic tx_hold_o,
  output logic wake_o,
  output logic ev_enter_o,
  output logic ev_leave_o
);
  lpi_state_e state_q, state_d;
  logic forced;

  assign forced = en_i && auto_i;

  always_comb begin
    state_d    = state_q;
    ev_enter_o = 1'b0;
    ev_leave_o = 1'b0;
    unique case (state_q)
      ST_OFF:
        if (link_i && forced && stable_i && !tx_pend_i) begin
          state_d    = ST_LPI;
          ev_enter_o = 1'b1;
        end
      ST_LPI:
        if (!link_i) begin
          state_d    = ST_OFF;
          ev_leave_o = 1'b1;
        end else if (!forced || tx_pend_i) begin
          state_d    = ST_WAKE;
          ev_leave_o = 1'b1;
        end
      ST_WAKE:
        if (!link_i || tw_done_i) state_d = ST_OFF;
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign tx_lpi_o  = (state_q == ST_LPI);
  assign wake_o    = (state_q == ST_WAKE);
  assign tx_hold_o = tx_lpi_o || wake_o;

  assert_entry_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_lpi_o) |-> $past(stable_i && en_i && auto_i && !tx_pend_i))
    else $error("LPI entered without permission");
  assert_abort_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_hold_o && !link_i) |=> !tx_hold_o)
    else $error("link loss did not abort");
  assert_wake_wait_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && link_i && !tw_done_i) |=> (wake_o && !tx_lpi_o))
    else $error("wake wait cut short");
endmodule

// File: rtl/lpi_status.sv
module lpi_status
  import lpi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ev_enter_i,
  input  logic             ev_leave_i,
  input  logic             rx_lpi_i,
  input  logic             rd_clr_i,
  input  logic             mask_i,
  output logic [NFLAG-1:0] flags_o,
  output logic             rx_live_o,
  output logic             irq_o
);
  logic             rx_q;
  logic [NFLAG-1:0] ev;

  always_comb begin
    ev             = '0;
    ev[F_TX_ENTER] = ev_enter_i;
    ev[F_TX_LEAVE] = ev_leave_i;
    ev[F_RX_RISE]  = rx_lpi_i && !rx_q;
    ev[F_RX_FALL]  = !rx_lpi_i && rx_q;
  end

  // a new event wins over a clearing read in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q    <= 1'b0;
      flags_o <= '0;
    end else begin
      rx_q    <= rx_lpi_i;
      flags_o <= (flags_o & {NFLAG{~rd_clr_i}}) | ev;
    end
  end

  assign rx_live_o = rx_q;
  assign irq_o     = (|flags_o) && !mask_i;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag_chk
    assert_flag_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev[i] |=> flags_o[i])
      else $error("event flag not captured");
  end

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && ev == '0) |=> (flags_o == '0))
    else $error("flags not cleared by read");
endmodule

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl
  import lpi_pkg::*;
#(
  parameter  int TW_W  = 16,
  parameter  int LS_W  = 11,
  localparam int REG_W = TW_W + LS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             us_tick_i,
  input  logic             ms_tick_i,
  input  logic             rx_lpi_i,
  input  logic             tx_pend_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic             reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             tx_lpi_o,
  output logic             tx_hold_o,
  output logic             irq_o
);
  logic link, en, auto_bit, mask, rd_clr, rx_live;
  logic stable, tw_done, wake, ev_enter, ev_leave;
  logic [TW_W-1:0]  tw;
  logic [LS_W-1:0]  ls;
  logic [NFLAG-1:0] flags;

  lpi_regs #(.TW_W(TW_W), .LS_W(LS_W), .REG_W(REG_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(reg_wr_i), .rd_i(reg_rd_i),
    .sel_i(reg_sel_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .flags_i(flags), .tx_live_i(tx_lpi_o), .rx_live_i(rx_live),
    .link_o(link), .en_o(en), .auto_o(auto_bit), .mask_o(mask),
    .tw_o(tw), .ls_o(ls), .rd_clr_o(rd_clr)
  );

  lpi_timers #(.TW_W(TW_W), .LS_W(LS_W)) u_timers (
    .clk_i(clk_i), .rst_ni(rst_ni), .link_i(link), .ms_tick_i(ms_tick_i),
    .us_tick_i(us_tick_i), .wake_i(wake), .ls_i(ls), .tw_i(tw),
    .stable_o(stable), .tw_done_o(tw_done)
  );

  lpi_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .link_i(link), .en_i(en), .auto_i(auto_bit),
    .stable_i(stable), .tx_pend_i(tx_pend_i), .tw_done_i(tw_done),
    .tx_lpi_o(tx_lpi_o), .tx_hold_o(tx_hold_o), .wake_o(wake),
    .ev_enter_o(ev_enter), .ev_leave_o(ev_leave)
  );

  lpi_status u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .ev_enter_i(ev_enter), .ev_leave_i(ev_leave),
    .rx_lpi_i(rx_lpi_i), .rd_clr_i(rd_clr), .mask_i(mask),
    .flags_o(flags), .rx_live_o(rx_live), .irq_o(irq_o)
  );

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_lpi_o) |-> (tx_hold_o || !link))
    else $error("hold released at LPI exit");
  assert_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o |-> !mask) and ((flags != '0 && !mask) |-> irq_o))
    else $error("interrupt mismatch");
endmodule

// File: tb/eee_lpi_ctrl_test.sv
module eee_lpi_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W = 27;
  localparam int WDOG  = 100000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic us_tick = 0, ms_tick = 0, rx_lpi = 0, tx_pend = 0;
  logic reg_wr = 0, reg_rd = 0, reg_sel = 0;
  logic [REG_W-1:0] reg_wdata = '0, reg_rdata;
  logic tx_lpi, tx_hold, irq;
  int total = 0, bad = 0, cycles = 0;
  logic [REG_W-1:0] rd;

  eee_lpi_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .us_tick_i(us_tick), .ms_tick_i(ms_tick),
    .rx_lpi_i(rx_lpi), .tx_pend_i(tx_pend), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tx_lpi_o(tx_lpi), .tx_hold_o(tx_hold), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles == WDOG) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<%0d", cycles, WDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(bit link, bit en, bit au, bit mask);
    @(negedge clk);
    reg_wr = 1; reg_sel = 0;
    reg_wdata = '0;
    reg_wdata[16] = link; reg_wdata[17] = en; reg_wdata[18] = au; reg_wdata[19] = mask;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic wr_tmr(int ls, int tw);
    @(negedge clk);
    reg_wr = 1; reg_sel = 1;
    reg_wdata = REG_W'((ls << 16) | tw);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_reg(bit sel, output logic [REG_W-1:0] v);
    @(negedge clk);
    reg_rd = 1; reg_sel = sel;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 0; reg_sel = 0;
  endtask

  task automatic ms_pulse();
    @(negedge clk); ms_tick = 1;
    @(negedge clk); ms_tick = 0;
  endtask

  task automatic us_pulse();
    @(negedge clk); us_tick = 1;
    @(negedge clk); us_tick = 0;
  endtask

  initial begin
    idle(3);
    chk("reset R6 hold", 32'(tx_hold), 0);
    chk("reset R9 irq", 32'(irq), 0);
    rst_n = 1;
    idle(2);
    rd_reg(0, rd);
    chk("reset R2 status", 32'(rd), 0);

    // R1 field placement
    @(negedge clk);
    reg_wr = 1; reg_sel = 1; reg_wdata = '1;
    @(negedge clk); reg_wr = 0;
    rd_reg(1, rd);
    chk("R1 timer readback", 32'(rd), 32'h07FF_FFFF);
    wr_tmr(5, 3);
    rd_reg(1, rd);
    chk("R1 fields", 32'(rd), (5 << 16) | 3);
    wr_cfg(0, 1, 0, 1);
    rd_reg(0, rd);
    chk("R2 cfg readback", 32'(rd), 32'h000A_0000);

    // R3 enable without automate: no entry
    wr_tmr(0, 0);
    wr_cfg(1, 1, 0, 0);
    idle(3);
    chk("R3 enable only", 32'(tx_lpi), 0);
    // R3 pending frame blocks entry
    tx_pend = 1;
    wr_cfg(1, 1, 1, 0);
    idle(3);
    chk("R3 pending blocks", 32'(tx_lpi), 0);
    tx_pend = 0;
    idle(2);
    chk("R3 entry after pending", 32'(tx_lpi), 1);
    wr_cfg(0, 0, 0, 0);
    idle(2);
    rd_reg(0, rd);

    // sweep settle and wake times
    for (int l = 0; l < 4; l++) begin
      for (int t = 0; t < 4; t++) begin
        wr_cfg(0, 0, 0, 0);
        wr_tmr(l, t);
        rd_reg(0, rd);
        wr_cfg(1, 1, 1, 0);
        if (l > 0) begin
          idle(3);
          chk("R3 no ticks yet", 32'(tx_lpi), 0);
          for (int k = 0; k < l - 1; k++) ms_pulse();
          idle(3);
          chk("R3 one tick short", 32'(tx_lpi), 0);
          ms_pulse();
        end
        idle(2);
        chk("R3 entry after settle", 32'(tx_lpi), 1);
        chk("R6 hold in LPI", 32'(tx_hold), 1);
        rd_reg(0, rd);
        chk("R7 entry flag", 32'(rd[3:0]), 4'b0001);
        chk("R2 live tx bit", 32'(rd[8]), 1);
        rd_reg(0, rd);
        chk("R8 cleared by read", 32'(rd[3:0]), 0);

        // pending frame wakes
        @(negedge clk); tx_pend = 1;
        idle(2);
        chk("R5 lpi drops", 32'(tx_lpi), 0);
        if (t > 0) begin
          chk("R5 hold in wake", 32'(tx_hold), 1);
          for (int k = 0; k < t - 1; k++) us_pulse();
          idle(3);
          chk("R5 one tick short", 32'(tx_hold), 1);
          us_pulse();
          idle(2);
        end
        chk("R5 hold released", 32'(tx_hold), 0);
        @(negedge clk); tx_pend = 0;
        idle(2);
        chk("R3 re-entry", 32'(tx_lpi), 1);
        rd_reg(0, rd);
        chk("R7 exit and entry flags", 32'(rd[3:0]), 4'b0011);

        // leaving by clearing enable/automate
        wr_cfg(1, 0, 0, 0);
        idle(1);
        chk("R5 forced leave", 32'(tx_lpi), 0);
        for (int k = 0; k < t; k++) us_pulse();
        idle(2);
        chk("R6 hold off in idle", 32'(tx_hold), 0);
        chk("R9 irq on flag", 32'(irq), 1);
        rd_reg(0, rd);
        chk("R7 exit flag", 32'(rd[3:0]), 4'b0010);
      end
    end

    // R4 restart of settle count and abort without wake wait
    wr_cfg(0, 0, 0, 0);
    wr_tmr(2, 5);
    wr_cfg(1, 1, 1, 0);
    ms_pulse();
    wr_cfg(0, 1, 1, 0);
    wr_cfg(1, 1, 1, 0);
    ms_pulse();
    idle(3);
    chk("R4 count restarted", 32'(tx_lpi), 0);
    ms_pulse();
    idle(2);
    chk("R4 entry after restart", 32'(tx_lpi), 1);
    rd_reg(0, rd);
    wr_cfg(0, 1, 1, 0);
    idle(1);
    chk("R4 abort lpi", 32'(tx_lpi), 0);
    chk("R4 abort no wake wait", 32'(tx_hold), 0);
    rd_reg(0, rd);
    chk("R7 exit on abort", 32'(rd[3:0]), 4'b0010);

    // R7 receive flags, R9 masking
    @(negedge clk); rx_lpi = 1;
    idle(2);
    rd_reg(0, rd);
    chk("R7 rx rise flag", 32'(rd[3:0]), 4'b0100);
    chk("R2 live rx bit", 32'(rd[9]), 1);
    @(negedge clk); rx_lpi = 0;
    idle(2);
    chk("R9 irq unmasked", 32'(irq), 1);
    wr_cfg(0, 0, 0, 1);
    idle(1);
    chk("R9 irq masked", 32'(irq), 0);
    rd_reg(0, rd);
    chk("R7 rx fall flag", 32'(rd[3:0]), 4'b1000);
    wr_cfg(0, 0, 0, 0);
    idle(1);
    chk("R9 irq idle", 32'(irq), 0);

    // R8 event in the same cycle as clearing read survives
    @(negedge clk);
    rx_lpi = 1; reg_rd = 1; reg_sel = 0;
    @(negedge clk);
    reg_rd = 0;
    rd_reg(0, rd);
    chk("R8 same-cycle event kept", 32'(rd[3:0]), 4'b0100);
    rd_reg(0, rd);
    chk("R8 then cleared", 32'(rd[3:0]), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule